// File: doc/BRIEF.md
# Instruction Debug Event Unit

This block holds the instruction-side debug event logic of an embedded processor core. It watches the address of every instruction at issue and a strobe for every retired instruction. When an enabled debug condition is met, it records the cause in a sticky status register and raises a one-cycle request for a debug exception. The exception vectoring and the pipeline are handled elsewhere.

Software programs the unit through a simple register write/read port. There is one control register, one status register and a set of instruction address compare registers. An address compare event needs four things: a processor-state debug-enable input, the internal debug mode bit, the comparator's own enable bit and an exact address match. An instruction-complete event fires on every retired instruction while its enable and internal debug mode are both set. The data compare enables and the external debug mode bit are kept in the control register but have no effect on events.

Top module: `debug_event_unit`

## Requirements
- R1: After reset, the control, status and compare registers read zero and `dbg_req_o` is low.
- R2: The control register (address 0) stores only bits 31 (external mode), 30 (internal mode), 27 (complete enable), 23..20 (compare 1..4 enables) and 19..16 (data compare enables). All other bits read zero, so writing all ones reads back 0xC8FF0000.
- R3: Compare register k (k = 1..4) sits at address k+1 and reads back the full address written to it. Addresses 6 and 7 read zero.
- R4: Comparator k fires in a cycle where all of these hold: `dbg_en_i`, control bit 30, control bit 24-k, `issue_valid_i`, and `issue_addr_i` equal to compare register k. The next cycle it sets status bit 24-k.
- R5: A cycle with `retire_i`, `dbg_en_i`, control bit 30 and control bit 27 all high sets status bit 27 on the next cycle, with or without an issue in that cycle.
- R6: While `dbg_en_i` is low, no status bit is set and `dbg_req_o` stays low.
- R7: While control bit 30 is clear, no status bit is set and `dbg_req_o` stays low, even when event enables are set.
- R8: Control bits 31 and 19..16 do not cause any event.
- R9: Status bits are sticky. A new event ORs its bit in and keeps the bits that were already set.
- R10: A write to the status register (address 1) clears each bit written as one and leaves each bit written as zero unchanged. If an event sets a bit in the same cycle that the write clears it, the bit stays set.
- R11: When several comparators match the same address, all of their status bits are set in the same cycle, with one request cycle.
- R12: `dbg_req_o` is high in exactly those cycles that follow a cycle with at least one event. Back-to-back event cycles keep it high without a gap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| dbg_en_i | input | 1 | Processor-state debug enable |
| issue_valid_i | input | 1 | An instruction issues this cycle |
| issue_addr_i | input | IADDR_W | Address of the issuing instruction |
| retire_i | input | 1 | An instruction completes this cycle |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | RA_W | Register write address |
| wr_data_i | input | 32 | Register write data |
| rd_addr_i | input | RA_W | Register read address |
| rd_data_o | output | 32 | Register read data (combinational) |
| dbg_req_o | output | 1 | Debug exception request pulse |

## Verification
The bench uses the default parameters: four comparators with 32-bit addresses. With four comparators, every enable and status position in the control and status registers is reachable. Two comparators are loaded with the same address, so one issue address can match several comparators at once. Full-width addresses make sure that an address differing only in its upper bits is not taken as a match.

// File: rtl/deu_pkg.sv
package deu_pkg;
  localparam int REG_W   = 32;
  localparam int MAX_CMP = 4;

  // Control/status bit positions
  localparam int B_EXT_MODE = 31;
  localparam int B_INT_MODE = 30;
  localparam int B_CPL      = 27;
  localparam int B_CMP1     = 23;  // comparator k uses B_CMP1 - k (k from 0)

  // Register addresses
  localparam int A_CTRL = 0;
  localparam int A_STAT = 1;
  localparam int A_CMP0 = 2;

  localparam logic [REG_W-1:0] CTRL_MASK = 32'hC8FF_0000;

  function automatic logic [REG_W-1:0] stat_mask(input int n_cmp);
    logic [REG_W-1:0] m;
    m = '0;
    m[B_CPL] = 1'b1;
    for (int k = 0; k < n_cmp; k++) m[B_CMP1-k] = 1'b1;
    return m;
  endfunction
endpackage

// File: rtl/deu_cmp.sv
module deu_cmp #(
  parameter int IADDR_W = 32
) (
  input  logic               en_i,
  input  logic               valid_i,
  input  logic [IADDR_W-1:0] addr_i,
  input  logic [IADDR_W-1:0] ref_i,
  output logic               hit_o
);
  assign hit_o = en_i && valid_i && (addr_i == ref_i);
endmodule

// File: rtl/deu_regs.sv
module deu_regs
  import deu_pkg::*;
#(
  parameter int NUM_CMP = 4,
  parameter int IADDR_W = 32,
  parameter int RA_W    = 3
) (
  input  logic                            clk_i,
  input  logic                            rst_ni,
  input  logic                            wr_en_i,
  input  logic [RA_W-1:0]                 wr_addr_i,
  input  logic [REG_W-1:0]                wr_data_i,
  input  logic [RA_W-1:0]                 rd_addr_i,
  input  logic [REG_W-1:0]                status_i,
  output logic [REG_W-1:0]                ctrl_o,
  output logic [NUM_CMP-1:0][IADDR_W-1:0] cmp_o,
  output logic                            stat_wr_o,
  output logic [REG_W-1:0]                rd_data_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ctrl_o <= '0;
    else if (wr_en_i && wr_addr_i == RA_W'(A_CTRL)) ctrl_o <= wr_data_i & CTRL_MASK;
  end

  for (genvar k = 0; k < NUM_CMP; k++) begin : g_cmp_reg
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) cmp_o[k] <= '0;
      else if (wr_en_i && wr_addr_i == RA_W'(A_CMP0 + k)) cmp_o[k] <= wr_data_i[IADDR_W-1:0];
    end
  end

  assign stat_wr_o = wr_en_i && (wr_addr_i == RA_W'(A_STAT));

  always_comb begin
    rd_data_o = '0;
    if (rd_addr_i == RA_W'(A_CTRL)) rd_data_o = ctrl_o;
    if (rd_addr_i == RA_W'(A_STAT)) rd_data_o = status_i;
    for (int k = 0; k < NUM_CMP; k++)
      if (rd_addr_i == RA_W'(A_CMP0 + k)) rd_data_o = REG_W'(cmp_o[k]);
  end
endmodule

// File: rtl/deu_status.sv
module deu_status
  import deu_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [REG_W-1:0] set_i,
  input  logic [REG_W-1:0] clr_i,
  output logic [REG_W-1:0] status_o,
  output logic             req_o
);
  // set wins over a same-cycle clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      status_o <= '0;
      req_o    <= 1'b0;
    end else begin
      status_o <= (status_o & ~clr_i) | set_i;
      req_o    <= |set_i;
    end
  end
endmodule

// File: rtl/debug_event_unit.sv
module debug_event_unit
  import deu_pkg::*;
#(
  parameter int NUM_CMP = 4,
  parameter int IADDR_W = 32,
  localparam int RA_W   = $clog2(A_CMP0 + NUM_CMP)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               dbg_en_i,
  input  logic               issue_valid_i,
  input  logic [IADDR_W-1:0] issue_addr_i,
  input  logic               retire_i,
  input  logic               wr_en_i,
  input  logic [RA_W-1:0]    wr_addr_i,
  input  logic [REG_W-1:0]   wr_data_i,
  input  logic [RA_W-1:0]    rd_addr_i,
  output logic [REG_W-1:0]   rd_data_o,
  output logic               dbg_req_o
);
  localparam logic [REG_W-1:0] STAT_MASK = stat_mask(NUM_CMP);

  logic [REG_W-1:0]                ctrl_q;
  logic [REG_W-1:0]                status_q;
  logic [NUM_CMP-1:0][IADDR_W-1:0] cmp_q;
  logic                            stat_wr;
  logic [NUM_CMP-1:0]              hit;
  logic [REG_W-1:0]                set_vec;
  logic [REG_W-1:0]                clr_vec;
  logic                            gate;

  deu_regs #(.NUM_CMP(NUM_CMP), .IADDR_W(IADDR_W), .RA_W(RA_W)) regs_i (
    .clk_i, .rst_ni, .wr_en_i, .wr_addr_i, .wr_data_i, .rd_addr_i,
    .status_i(status_q), .ctrl_o(ctrl_q), .cmp_o(cmp_q),
    .stat_wr_o(stat_wr), .rd_data_o
  );

  assign gate = dbg_en_i && ctrl_q[B_INT_MODE];

  for (genvar k = 0; k < NUM_CMP; k++) begin : g_cmp
    deu_cmp #(.IADDR_W(IADDR_W)) cmp_i (
      .en_i   (gate && ctrl_q[B_CMP1-k]),
      .valid_i(issue_valid_i),
      .addr_i (issue_addr_i),
      .ref_i  (cmp_q[k]),
      .hit_o  (hit[k])
    );
  end

  always_comb begin
    set_vec = '0;
    set_vec[B_CPL] = gate && ctrl_q[B_CPL] && retire_i;
    for (int k = 0; k < NUM_CMP; k++) set_vec[B_CMP1-k] = hit[k];
  end

  assign clr_vec = stat_wr ? (wr_data_i & STAT_MASK) : '0;

  deu_status status_i (
    .clk_i, .rst_ni, .set_i(set_vec), .clr_i(clr_vec),
    .status_o(status_q), .req_o(dbg_req_o)
  );
endmodule

// File: rtl/deu_checker.sv
module deu_checker
  import deu_pkg::*;
#(
  parameter int RA_W = 3
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             dbg_en_i,
  input logic             retire_i,
  input logic             wr_en_i,
  input logic [RA_W-1:0]  wr_addr_i,
  input logic [REG_W-1:0] ctrl_i,
  input logic [REG_W-1:0] status_i,
  input logic             dbg_req_o
);
  logic stat_wr;
  assign stat_wr = wr_en_i && (wr_addr_i == RA_W'(A_STAT));

  assert_ctrl_reserved_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctrl_i & ~CTRL_MASK) == '0);

  assert_cpl_sets_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dbg_en_i && retire_i && ctrl_i[B_INT_MODE] && ctrl_i[B_CPL]) |=> (status_i[B_CPL] && dbg_req_o));

  assert_no_req_disabled_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !dbg_en_i |=> !dbg_req_o);

  assert_no_req_int_off_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ctrl_i[B_INT_MODE] |=> !dbg_req_o);

  assert_sticky_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !stat_wr |=> ((status_i & $past(status_i)) == $past(status_i)));

  assert_req_has_cause_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dbg_req_o |-> (status_i != '0));
endmodule

bind debug_event_unit deu_checker #(.RA_W(RA_W)) chk_i (
  .clk_i, .rst_ni, .dbg_en_i, .retire_i, .wr_en_i, .wr_addr_i,
  .ctrl_i(ctrl_q), .status_i(status_q), .dbg_req_o
);

// File: tb/debug_event_unit_tb_top.sv
module debug_event_unit_tb_top;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        dbg_en_i = 1'b0;
  logic        issue_valid_i = 1'b0;
  logic [31:0] issue_addr_i = '0;
  logic        retire_i = 1'b0;
  logic        wr_en_i = 1'b0;
  logic [2:0]  wr_addr_i = '0;
  logic [31:0] wr_data_i = '0;
  logic [2:0]  rd_addr_i = '0;
  logic [31:0] rd_data_o;
  logic        dbg_req_o;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;

  localparam logic [31:0] CTRL_ALL = 32'h48F0_0000;

  always #10 clk_i = ~clk_i;

  debug_event_unit dut_i (
    .clk_i, .rst_ni, .dbg_en_i, .issue_valid_i, .issue_addr_i, .retire_i,
    .wr_en_i, .wr_addr_i, .wr_data_i, .rd_addr_i, .rd_data_o, .dbg_req_o
  );

  typedef struct packed {
    logic        en;
    logic        vld;
    logic [31:0] addr;
    logic        ret;
    logic [31:0] exp_st;
    logic        exp_req;
    logic [7:0]  rid;
  } row_t;

  // cmp1=0x1000 cmp2=0x2000 cmp3=0x1000 cmp4=0x3000, control = CTRL_ALL
  localparam row_t ROWS [9] = '{
    '{1'b1, 1'b1, 32'h0000_1000, 1'b0, 32'h00A0_0000, 1'b1, 8'd11},
    '{1'b1, 1'b1, 32'h0000_2000, 1'b0, 32'h0040_0000, 1'b1, 8'd4},
    '{1'b1, 1'b1, 32'h0000_3000, 1'b0, 32'h0010_0000, 1'b1, 8'd4},
    '{1'b1, 1'b1, 32'h0000_4000, 1'b0, 32'h0000_0000, 1'b0, 8'd4},
    '{1'b1, 1'b1, 32'h8000_1000, 1'b0, 32'h0000_0000, 1'b0, 8'd4},
    '{1'b0, 1'b1, 32'h0000_2000, 1'b1, 32'h0000_0000, 1'b0, 8'd6},
    '{1'b1, 1'b0, 32'h0000_2000, 1'b0, 32'h0000_0000, 1'b0, 8'd4},
    '{1'b1, 1'b0, 32'h0000_0000, 1'b1, 32'h0800_0000, 1'b1, 8'd5},
    '{1'b1, 1'b1, 32'h0000_3000, 1'b1, 32'h0810_0000, 1'b1, 8'd5}
  };

  task automatic tick();
    @(posedge clk_i);
    @(negedge clk_i);
  endtask

  task automatic chk(input string rid, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s act=%h exp=%h", rid, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    wr_en_i = 1'b1; wr_addr_i = a; wr_data_i = d;
    tick();
    wr_en_i = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] v);
    rd_addr_i = a;
    #1 v = rd_data_o;
  endtask

  task automatic drive(input logic en, input logic vld, input logic [31:0] a, input logic ret);
    dbg_en_i = en; issue_valid_i = vld; issue_addr_i = a; retire_i = ret;
  endtask

  task automatic idle();
    drive(1'b0, 1'b0, '0, 1'b0);
  endtask

  initial begin
    #(20 * 200000);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog act=hung exp=finished");
      $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    repeat (2) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);

    // R1: reset values
    for (int a = 0; a < 6; a++) begin
      rd(3'(a), v);
      chk("R1", v, 32'h0);
    end
    chk("R1", {31'h0, dbg_req_o}, 32'h0);

    // R2: control field mask
    wr(3'd0, 32'hFFFF_FFFF);
    rd(3'd0, v); chk("R2", v, 32'hC8FF_0000);

    // R3: compare registers
    wr(3'd2, 32'h0000_1000);
    wr(3'd3, 32'h0000_2000);
    wr(3'd4, 32'h0000_1000);
    wr(3'd5, 32'h0000_3000);
    rd(3'd2, v); chk("R3", v, 32'h0000_1000);
    rd(3'd3, v); chk("R3", v, 32'h0000_2000);
    rd(3'd4, v); chk("R3", v, 32'h0000_1000);
    rd(3'd5, v); chk("R3", v, 32'h0000_3000);
    rd(3'd6, v); chk("R3", v, 32'h0);
    wr(3'd1, 32'hFFFF_FFFF);

    // Table walk: R4 R5 R6 R11
    wr(3'd0, CTRL_ALL);
    for (int i = 0; i < 9; i++) begin
      drive(ROWS[i].en, ROWS[i].vld, ROWS[i].addr, ROWS[i].ret);
      tick();
      idle();
      chk($sformatf("R%0d row%0d req", ROWS[i].rid, i), {31'h0, dbg_req_o}, {31'h0, ROWS[i].exp_req});
      rd(3'd1, v);
      chk($sformatf("R%0d row%0d status", ROWS[i].rid, i), v, ROWS[i].exp_st);
      tick();
      chk("R12 req one cycle", {31'h0, dbg_req_o}, 32'h0);
      wr(3'd1, 32'hFFFF_FFFF);
    end

    // R7: internal mode off
    wr(3'd0, 32'h08F0_0000);
    drive(1'b1, 1'b1, 32'h0000_1000, 1'b1);
    tick(); idle();
    chk("R7 req", {31'h0, dbg_req_o}, 32'h0);
    rd(3'd1, v); chk("R7 status", v, 32'h0);

    // R8: external mode and data compare bits only
    wr(3'd0, 32'hC00F_0000);
    drive(1'b1, 1'b1, 32'h0000_1000, 1'b1);
    tick(); idle();
    chk("R8 req", {31'h0, dbg_req_o}, 32'h0);
    rd(3'd1, v); chk("R8 status", v, 32'h0);

    // R9: sticky accumulation
    wr(3'd0, CTRL_ALL);
    drive(1'b1, 1'b1, 32'h0000_2000, 1'b0);
    tick();
    drive(1'b1, 1'b1, 32'h0000_3000, 1'b0);
    tick(); idle();
    rd(3'd1, v); chk("R9", v, 32'h0050_0000);

    // R10: write-one-to-clear
    wr(3'd1, 32'h0040_0000);
    rd(3'd1, v); chk("R10 clear one", v, 32'h0010_0000);
    wr(3'd1, 32'h0000_0000);
    rd(3'd1, v); chk("R10 zero write", v, 32'h0010_0000);
    drive(1'b1, 1'b1, 32'h0000_3000, 1'b0);
    wr(3'd1, 32'h0010_0000);
    idle();
    rd(3'd1, v); chk("R10 set wins", v, 32'h0010_0000);
    chk("R10 req", {31'h0, dbg_req_o}, 32'h1);
    wr(3'd1, 32'hFFFF_FFFF);

    // R12: back-to-back events
    drive(1'b1, 1'b1, 32'h0000_2000, 1'b0);
    tick();
    chk("R12 first", {31'h0, dbg_req_o}, 32'h1);
    drive(1'b1, 1'b1, 32'h0000_1000, 1'b0);
    tick(); idle();
    chk("R12 second", {31'h0, dbg_req_o}, 32'h1);
    tick();
    chk("R12 drop", {31'h0, dbg_req_o}, 32'h0);
    rd(3'd1, v); chk("R12 status", v, 32'h00E0_0000);

    done = 1;
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule